// File: doc/BRIEF.md
# Packed 128-bit SIMD Add/Subtract and Logic Unit

This block performs lane-parallel arithmetic and bitwise logic on two 128-bit operands. The arithmetic treats the operands as sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Each lane can add or subtract with wrap-around, with signed saturation or with unsigned saturation. A mixed mode adds in some 16-bit lanes and subtracts in the others. Logic operations (AND, OR, XOR and NOR) act on the full 128-bit width.

A pipeline issue stage presents one operation per cycle. Each operation carries a 5-bit opcode, both operands and the index of the destination register. One clock edge later the block presents the result, the destination index, a valid strobe and a write enable for the register file. Destination index zero names a register that can never be written, so for that index the write enable is held low.

Top module: `simd128_alu`

## Requirements
- R1: While `rst_n` is low, at a rising edge, `out_valid`, `wr_en`, `wr_idx` and `result` are all cleared to zero.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising edge. `result` and `wr_idx` are loaded at an edge only when `in_valid` is high at that edge.
- R3: In wrap mode every lane computes `a+b` or `a-b` modulo 2^lane-width. No carry or borrow passes from one lane into the next.
- R4: In signed-saturation mode, a lane result that overflows is clamped to the lane's largest positive value (0x7F, 0x7FFF or 0x7FFFFFFF) or its most negative value (0x80, 0x8000 or 0x80000000).
- R5: In unsigned-saturation mode, an addition that overflows gives all ones in that lane, and a subtraction that underflows gives zero.
- R6: In the mixed 16-bit mode, even lanes 0, 2, 4 and 6 (lane 0 at bits 15:0) compute `a+b`, and odd lanes compute `a-b`, both with wrap-around.
- R7: The logic codes give `a&b`, `a|b`, `a^b` and `~(a|b)` across all 128 bits.
- R8: When `rd_idx` is 0, `wr_en` stays low for that operation while `out_valid` and `result` still appear as normal. A valid operation to any other index raises `wr_en` for exactly the cycle in which `out_valid` is high.
- R9: Opcode fields: `op[4:3]` is the mode (00 wrap, 01 signed saturation, 10 unsigned saturation, 11 miscellaneous). `op[2]` selects subtract in the three arithmetic modes. `op[1:0]` is the lane width (00 8-bit, 01 16-bit, 10 32-bit). In mode 11, `op[2:0]` selects 000 AND, 001 OR, 010 XOR, 011 NOR or 100 mixed 16-bit add/subtract.
- R10: Reserved codes give an all-zero `result` and otherwise follow R2 and R8. The reserved codes are lane width 11 in an arithmetic mode, and 101, 110 or 111 in mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code, fields as in R9 |
| rd_idx | input | 5 | Destination register index |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand (subtrahend for subtraction) |
| out_valid | output | 1 | Result registered from the previous cycle |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Destination index carried with the result |
| result | output | 128 | Registered lane-wise result |

## Verification
Every output of this block is due at the first rising edge after the edge that samples `in_valid`. This holds for the result, the write enable and the carried index, whatever the mode. The bench drives each operation on a falling edge and lets exactly one rising edge pass. It then reads the outputs a short time after that edge, before the next edge, and drops `in_valid` at the same moment. One extra idle edge then confirms that `out_valid` and `wr_en` return low at the expected moment.

// File: rtl/simd128_pkg.sv
// Package: shared opcode fields and mode codes for the 128-bit lane unit.
// Assumes a 5-bit opcode split into mode, subtract flag and lane-width fields.
package simd128_pkg;

    localparam int OP_W = 5;

    localparam logic [1:0] MODE_WRAP = 2'b00;
    localparam logic [1:0] MODE_SSAT = 2'b01;
    localparam logic [1:0] MODE_USAT = 2'b10;
    localparam logic [1:0] MODE_MISC = 2'b11;

    localparam logic [1:0] LW_8  = 2'b00;
    localparam logic [1:0] LW_16 = 2'b01;
    localparam logic [1:0] LW_32 = 2'b10;

    localparam logic [2:0] MISC_AND   = 3'b000;
    localparam logic [2:0] MISC_OR    = 3'b001;
    localparam logic [2:0] MISC_XOR   = 3'b010;
    localparam logic [2:0] MISC_NOR   = 3'b011;
    localparam logic [2:0] MISC_MIXED = 3'b100;

    typedef struct packed {
        logic [1:0] mode;
        logic       sub;
        logic [1:0] lw;
    } op_fields_t;

endpackage

// File: rtl/simd_lane_addsub.sv
// Module: one lane of add/subtract with optional signed or unsigned clamping.
// Assumes sat_s and sat_u are never both high; with both low it wraps.
module simd_lane_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat_s,
    input  logic         sat_u,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic         ovf_s;
    logic         u_over;
    logic         u_under;

    // Shared adder: subtraction is a plus inverted b plus one.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    end

    // Overflow detection for both signed and unsigned interpretations.
    always_comb begin
        ovf_s   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        u_over  = !sub && sum[W];
        u_under = sub && !sum[W];
    end

    // Clamp the wrapped sum according to the requested saturation kind.
    always_comb begin
        y = sum[W-1:0];
        if (sat_s && ovf_s) begin
            y = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else if (sat_u && u_over) begin
            y = {W{1'b1}};
        end else if (sat_u && u_under) begin
            y = {W{1'b0}};
        end
    end

endmodule

// File: rtl/simd_lane_bank.sv
// Module: a row of identical lanes covering the full data width at one lane width.
// Assumes DATA_W is a multiple of LANE_W; lanes share no carry.
module simd_lane_bank #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8,
    localparam int NL    = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [NL-1:0]     sub_mask,
    input  logic              sat_s,
    input  logic              sat_u,
    output logic [DATA_W-1:0] y
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane_addsub #(.W(LANE_W)) u_lane (
            .a     (a[i*LANE_W +: LANE_W]),
            .b     (b[i*LANE_W +: LANE_W]),
            .sub   (sub_mask[i]),
            .sat_s (sat_s),
            .sat_u (sat_u),
            .y     (y[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_bitwise.sv
// Module: full-width bitwise logic, selected by a 2-bit code (AND, OR, XOR, NOR).
// Assumes the selector encoding of the package MISC_* low bits.
module simd_bitwise #(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] y
);

    // Pick one of the four bitwise functions.
    always_comb begin
        unique case (sel)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

endmodule

// File: rtl/simd128_alu.sv
// Module: top of the packed lane unit; decodes the opcode, selects a bank and
// registers result, index, valid and write enable one edge after issue.
// Assumes an opcode layout as in simd128_pkg and that index zero is read-only.
module simd128_alu
    import simd128_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int IDX_W   = 5,
    localparam int NL_16  = DATA_W / 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] result
);

    localparam int NL_8  = DATA_W / 8;
    localparam int NL_32 = DATA_W / 32;

    op_fields_t        f;
    logic              is_arith;
    logic              is_mixed;
    logic              sat_s;
    logic              sat_u;
    logic [NL_8-1:0]   sub8;
    logic [NL_16-1:0]  sub16;
    logic [NL_32-1:0]  sub32;
    logic [DATA_W-1:0] y8;
    logic [DATA_W-1:0] y16;
    logic [DATA_W-1:0] y32;
    logic [DATA_W-1:0] ylog;
    logic [DATA_W-1:0] nxt;

    // Split the opcode into its fields and derive the bank controls.
    always_comb begin
        f        = op_code;
        is_arith = (f.mode != MODE_MISC);
        is_mixed = (f.mode == MODE_MISC) && ({f.sub, f.lw} == MISC_MIXED);
        sat_s    = (f.mode == MODE_SSAT);
        sat_u    = (f.mode == MODE_USAT);
        sub8     = {NL_8{f.sub}};
        sub32    = {NL_32{f.sub}};
        for (int i = 0; i < NL_16; i++) begin
            sub16[i] = is_mixed ? i[0] : f.sub;
        end
    end

    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(8)) u_bank8 (
        .a(src_a), .b(src_b), .sub_mask(sub8), .sat_s(sat_s), .sat_u(sat_u), .y(y8)
    );

    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(16)) u_bank16 (
        .a(src_a), .b(src_b), .sub_mask(sub16), .sat_s(sat_s), .sat_u(sat_u), .y(y16)
    );

    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(32)) u_bank32 (
        .a(src_a), .b(src_b), .sub_mask(sub32), .sat_s(sat_s), .sat_u(sat_u), .y(y32)
    );

    simd_bitwise #(.DATA_W(DATA_W)) u_logic (
        .a(src_a), .b(src_b), .sel(f.lw), .y(ylog)
    );

    // Choose the bank output that the opcode names; reserved codes give zero.
    always_comb begin
        nxt = '0;
        if (is_arith) begin
            case (f.lw)
                LW_8:    nxt = y8;
                LW_16:   nxt = y16;
                LW_32:   nxt = y32;
                default: nxt = '0;
            endcase
        end else if (!f.sub) begin
            nxt = ylog;
        end else if (is_mixed) begin
            nxt = y16;
        end
    end

    // Output stage: one register level between issue and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && (rd_idx != '0);
            if (in_valid) begin
                wr_idx <= rd_idx;
                result <= nxt;
            end
        end
    end

    // R2: a valid issue is followed by a valid result on the next edge.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: index zero never produces a write strobe.
    a_r8_zero_dest_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == '0) |-> !wr_en);

    // R8: no write strobe without a valid result.
    a_r8_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);

    // R7: NOR result seen at the port matches the operands of the issue cycle.
    a_r7_nor_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == {MODE_MISC, MISC_NOR}) |=>
            (result == ~($past(src_a) | $past(src_b))));

    // R3: lowest 32-bit lane of a wrap add equals the modulo sum.
    a_r3_wrap_add32_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == {MODE_WRAP, 1'b0, LW_32}) |=>
            (result[31:0] == $past(src_a[31:0] + src_b[31:0])));

    // R5: unsigned saturating 8-bit add never yields a lane below its first operand.
    a_r5_usat_add8_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == {MODE_USAT, 1'b0, LW_8}) |=>
            (result[7:0] >= $past(src_a[7:0])));

endmodule

// File: tb/simd128_alu_bench.sv
// Directed bench: one task per scenario, each comparing against a lane model.
module simd128_alu_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   op_code = '0;
    logic [4:0]   rd_idx = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic         wr_en;
    logic [4:0]   wr_idx;
    logic [127:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    simd128_alu u_simd128_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .rd_idx(rd_idx), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .result(result)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles=%0d expected <100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Lane model from the requirements (R3..R7, R9, R10).
    function automatic logic [127:0] model(input logic [4:0] op,
                                           input logic [127:0] a,
                                           input logic [127:0] b);
        logic [127:0] res = '0;
        logic [1:0] mode = op[4:3];
        logic       sub = op[2];
        int         w;
        logic       mixed = 1'b0;
        if (mode == 2'b11) begin
            case (op[2:0])
                3'b000: return a & b;
                3'b001: return a | b;
                3'b010: return a ^ b;
                3'b011: return ~(a | b);
                3'b100: begin mixed = 1'b1; w = 16; end
                default: return '0;
            endcase
        end else begin
            if (op[1:0] == 2'b11) return '0;
            w = 8 << op[1:0];
        end
        for (int l = 0; l < 128 / w; l++) begin
            longint mask = (longint'(1) << w) - 1;
            longint half = longint'(1) << (w - 1);
            logic [127:0] ta = a >> (l * w);
            logic [127:0] tb = b >> (l * w);
            longint ua = longint'(ta[63:0]) & mask;
            longint ub = longint'(tb[63:0]) & mask;
            longint sa = (ua >= half) ? ua - (mask + 1) : ua;
            longint sb = (ub >= half) ? ub - (mask + 1) : ub;
            logic   ls = mixed ? l[0] : sub;
            longint r;
            if (!mixed && mode == 2'b01) begin
                r = ls ? sa - sb : sa + sb;
                if (r > half - 1) r = half - 1;
                if (r < -half) r = -half;
            end else if (!mixed && mode == 2'b10) begin
                r = ls ? ua - ub : ua + ub;
                if (r > mask) r = mask;
                if (r < 0) r = 0;
            end else begin
                r = ls ? ua - ub : ua + ub;
            end
            res = res | (128'(r & mask) << (l * w));
        end
        return res;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one op, wait one edge, compare all outputs.
    task automatic issue(input string req, input logic [4:0] op, input logic [4:0] rd,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; rd_idx = rd; src_a = a; src_b = b;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        check(req, "result", result, model(op, a, b));
        check("R2", "out_valid", 128'(out_valid), 128'(1));
        check("R8", "wr_en", 128'(wr_en), 128'(rd != 0));
        check("R2", "wr_idx", 128'(wr_idx), 128'(rd));
    endtask

    task automatic t_reset;
        @(posedge clk); #2;
        check("R1", "out_valid", 128'(out_valid), 0);
        check("R1", "wr_en", 128'(wr_en), 0);
        check("R1", "result", result, 0);
        check("R1", "wr_idx", 128'(wr_idx), 0);
    endtask

    task automatic t_wrap;
        issue("R3", 5'b00_0_00, 5'd3, {16{8'hFF}}, {16{8'h01}});
        issue("R3", 5'b00_1_10, 5'd4, {4{32'h0000_0000}}, {4{32'h0000_0001}});
        issue("R3", 5'b00_0_01, 5'd5, {8{16'h8001}}, {8{16'h8001}});
        issue("R3", 5'b00_1_00, 5'd6, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
              128'h1111_2222_3333_4444_5555_6666_7777_8888);
    endtask

    task automatic t_ssat;
        issue("R4", 5'b01_0_01, 5'd7, {8{16'h7FFF}}, {8{16'h0001}});
        issue("R4", 5'b01_1_01, 5'd7, {8{16'h8000}}, {8{16'h0001}});
        issue("R4", 5'b01_0_00, 5'd8, {8{8'h80, 8'h7F}}, {8{8'hFF, 8'h01}});
        issue("R4", 5'b01_1_10, 5'd9, {2{32'h7FFF_FFFF, 32'h8000_0000}},
              {2{32'h8000_0000, 32'h0000_0005}});
        issue("R4", 5'b01_0_10, 5'd9, {4{32'h1000_0000}}, {4{32'h2000_0000}});
    endtask

    task automatic t_usat;
        issue("R5", 5'b10_0_00, 5'd10, {8{8'hF0, 8'h10}}, {8{8'h20, 8'h20}});
        issue("R5", 5'b10_1_01, 5'd11, {4{16'h0005, 16'h9000}}, {4{16'h0006, 16'h1000}});
        issue("R5", 5'b10_0_10, 5'd12, {4{32'hFFFF_FFF0}}, {4{32'h0000_0100}});
        issue("R5", 5'b10_1_10, 5'd12, {4{32'h0000_0001}}, {4{32'h0000_0002}});
    endtask

    task automatic t_mixed;
        issue("R6", 5'b11_100, 5'd13, {8{16'h0010}}, {8{16'h0003}});
        issue("R6", 5'b11_100, 5'd13, {8{16'hFFFF}}, {8{16'h0002}});
    endtask

    task automatic t_logic;
        logic [127:0] a = 128'hF0F0_FFFF_0000_1234_5678_9ABC_DEF0_AAAA;
        logic [127:0] b = 128'h0FF0_00FF_FFFF_4321_8765_CBA9_0FED_5555;
        issue("R7", 5'b11_000, 5'd14, a, b);
        issue("R7", 5'b11_001, 5'd15, a, b);
        issue("R7", 5'b11_010, 5'd16, a, b);
        issue("R7", 5'b11_011, 5'd17, a, b);
    endtask

    task automatic t_zero_dest;
        issue("R8", 5'b00_0_00, 5'd0, {16{8'h11}}, {16{8'h22}});
        issue("R8", 5'b11_011, 5'd0, '0, '0);
    endtask

    task automatic t_reserved;
        issue("R10", 5'b00_0_11, 5'd18, {16{8'h5A}}, {16{8'h33}});
        issue("R10", 5'b11_101, 5'd19, {16{8'h5A}}, {16{8'h33}});
        issue("R10", 5'b11_111, 5'd20, {16{8'h5A}}, {16{8'h33}});
    endtask

    // R2: after an idle edge the strobes drop and the result holds.
    task automatic t_idle;
        logic [127:0] held;
        issue("R9", 5'b00_0_01, 5'd21, {8{16'h1234}}, {8{16'h1111}});
        held = result;
        @(posedge clk); #2;
        check("R2", "idle out_valid", 128'(out_valid), 0);
        check("R2", "idle wr_en", 128'(wr_en), 0);
        check("R2", "idle result hold", result, held);
    endtask

    // Sweep: every opcode against a pseudo-random operand set (R9).
    task automatic t_sweep;
        logic [127:0] a = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;
        logic [127:0] b = 128'h8000_7FFF_FF80_017F_0080_FFFF_7F7F_8181;
        for (int op = 0; op < 32; op++) begin
            issue("R9", op[4:0], 5'(op + 1), a, b);
            a = {a[126:0], a[127] ^ a[100] ^ a[62] ^ a[5]};
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_wrap();
        t_ssat();
        t_usat();
        t_mixed();
        t_logic();
        t_zero_dest();
        t_reserved();
        t_idle();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule